// File: doc/BRIEF.md
# Pareto Replacement Decision Unit

This pipeline stage judges, for each newly evaluated offspring, whether it should overwrite the parent chosen for it in the population. It receives the offspring's objective fitness vector, the parent's fitness vector and the parent's population address together with the first beat of the offspring chromosome. The chromosome itself streams through in fixed-width beats. Every beat goes out with a one-bit selected flag, the offspring fitness vector and the parent address, so the next stage can perform the write.

Two policies are available. In Pareto mode the flag is raised only when the offspring dominates the parent. In single-objective mode only one configured objective is compared. The policy and the objective index are static settings and are captured while reset is held.

Top module: `pareto_repl_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In Pareto mode (cfg_biased=0), out_sel is 1 exactly when the offspring is greater than or equal to the parent on every objective and strictly greater on at least one. Objective j occupies bits [j*FIT_W +: FIT_W] of each fitness bus, and each value is unsigned.
- R3: In Pareto mode, an offspring fitness vector equal to the parent's gives out_sel = 0.
- R4: In single-objective mode (cfg_biased=1), out_sel is 1 exactly when the offspring's objective cfg_obj is strictly greater than the parent's. A tie gives 0, and the other objectives have no effect.
- R5: cfg_biased and cfg_obj are captured on every clock edge at which rst is 1. Changes made after rst falls have no effect until the next reset.
- R6: Each individual is CHROM_BEATS = ceil(CHROM_W/BEAT_W) beats long, with CHROM_BEATS = 3 at the defaults. Every beat reaches out_beat unchanged and in order, and out_last is 1 only on the final beat.
- R7: The decision, the offspring fitness and the parent address are taken on the first beat of an individual and held on its remaining beats. Fitness and address inputs presented with later beats are ignored.
- R8: in_ready equals !out_valid || out_ready. An accepted beat appears at the outputs one cycle later. While out_valid=1 and out_ready=0, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| cfg_biased | input | 1 | 0 = Pareto dominance, 1 = single-objective policy |
| cfg_obj | input | OBJ_IW | Objective compared in single-objective mode |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when in_valid is also high |
| in_beat | input | BEAT_W | Chromosome beat |
| in_off_fit | input | NOBJ*FIT_W | Offspring fitness vector (sampled on the first beat) |
| in_par_fit | input | NOBJ*FIT_W | Parent fitness vector (sampled on the first beat) |
| in_par_addr | input | ADDR_W | Parent population address (sampled on the first beat) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_beat | output | BEAT_W | Chromosome beat |
| out_last | output | 1 | Final beat of an individual |
| out_sel | output | 1 | Offspring should replace the parent |
| out_off_fit | output | NOBJ*FIT_W | Offspring fitness vector |
| out_par_addr | output | ADDR_W | Parent population address |

## Verification
The hardest case to reach from the ports is a downstream stall in the middle of an individual. While the stall lasts, the input must stay blocked, and the held beat and flag must not be disturbed by new sideband values. The bench reaches this case by dropping out_ready after the first beat is accepted, offering the second beat with scrambled fitness values, and checking that nothing moves until out_ready returns. Ties in Pareto mode are made frequent by drawing random objectives from only four values. The configuration freeze is exercised by flipping cfg_biased after reset with a fitness pair on which the two policies disagree.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic {POL_PARETO = 1'b0, POL_SINGLE = 1'b1} policy_e;

  function automatic int unsigned beats_for(input int unsigned n, input int unsigned m);
    return (n + m - 1) / m;
  endfunction
endpackage

// File: rtl/prd_dominance.sv
module prd_dominance #(
  parameter int NOBJ  = 2,
  parameter int FIT_W = 16
) (
  input  logic [NOBJ*FIT_W-1:0] a_fit,
  input  logic [NOBJ*FIT_W-1:0] b_fit,
  output logic                  a_dom_b
);
  logic [NOBJ-1:0] ge, gt;

  for (genvar j = 0; j < NOBJ; j++) begin : g_obj
    assign ge[j] = a_fit[j*FIT_W +: FIT_W] >= b_fit[j*FIT_W +: FIT_W];
    assign gt[j] = a_fit[j*FIT_W +: FIT_W] >  b_fit[j*FIT_W +: FIT_W];
  end

  assign a_dom_b = (&ge) && (|gt);
endmodule

// File: rtl/prd_decide.sv
module prd_decide
  import prd_pkg::*;
#(
  parameter int NOBJ   = 2,
  parameter int FIT_W  = 16,
  parameter int OBJ_IW = 1
) (
  input  policy_e               policy,
  input  logic [OBJ_IW-1:0]     obj_idx,
  input  logic [NOBJ*FIT_W-1:0] off_fit,
  input  logic [NOBJ*FIT_W-1:0] par_fit,
  output logic                  sel
);
  logic dom;
  logic single_gt;
  logic [FIT_W-1:0] off_one, par_one;

  prd_dominance #(.NOBJ(NOBJ), .FIT_W(FIT_W)) u_dom (
    .a_fit  (off_fit),
    .b_fit  (par_fit),
    .a_dom_b(dom)
  );

  always_comb begin
    off_one   = '0;
    par_one   = '0;
    single_gt = 1'b0;
    if (int'(obj_idx) < NOBJ) begin
      off_one   = off_fit[int'(obj_idx)*FIT_W +: FIT_W];
      par_one   = par_fit[int'(obj_idx)*FIT_W +: FIT_W];
      single_gt = off_one > par_one;
    end
  end

  assign sel = (policy == POL_SINGLE) ? single_gt : dom;

  // R3
  always_comb begin
    if (off_fit == par_fit) begin
      equal_vec_chk: assert (!dom) else $error("equal vectors reported as dominating");
    end
  end
endmodule

// File: rtl/prd_beat_ctr.sv
module prd_beat_ctr #(
  parameter int BEATS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic first,
  output logic last
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  logic [CW-1:0] cnt;

  assign first = (cnt == '0);
  assign last  = (cnt == CW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + 1'b1;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < BEATS) else $error("beat counter out of range");
endmodule

// File: rtl/pareto_repl_unit.sv
module pareto_repl_unit
  import prd_pkg::*;
#(
  parameter int NOBJ    = 2,
  parameter int FIT_W   = 16,
  parameter int CHROM_W = 40,
  parameter int BEAT_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int OBJ_IW  = (NOBJ > 1) ? $clog2(NOBJ) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_biased,
  input  logic [OBJ_IW-1:0]     cfg_obj,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BEAT_W-1:0]     in_beat,
  input  logic [NOBJ*FIT_W-1:0] in_off_fit,
  input  logic [NOBJ*FIT_W-1:0] in_par_fit,
  input  logic [ADDR_W-1:0]     in_par_addr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [BEAT_W-1:0]     out_beat,
  output logic                  out_last,
  output logic                  out_sel,
  output logic [NOBJ*FIT_W-1:0] out_off_fit,
  output logic [ADDR_W-1:0]     out_par_addr
);
  localparam int CHROM_BEATS = beats_for(CHROM_W, BEAT_W);

  policy_e           policy_q;
  logic [OBJ_IW-1:0] obj_q;
  logic              acc, first, last, sel_now;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      policy_q <= policy_e'(cfg_biased);
      obj_q    <= cfg_obj;
    end
  end

  prd_beat_ctr #(.BEATS(CHROM_BEATS)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .step (acc),
    .first(first),
    .last (last)
  );

  prd_decide #(.NOBJ(NOBJ), .FIT_W(FIT_W), .OBJ_IW(OBJ_IW)) u_dec (
    .policy (policy_q),
    .obj_idx(obj_q),
    .off_fit(in_off_fit),
    .par_fit(in_par_fit),
    .sel    (sel_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_beat     <= '0;
      out_last     <= 1'b0;
      out_sel      <= 1'b0;
      out_off_fit  <= '0;
      out_par_addr <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_beat  <= in_beat;
      out_last  <= last;
      if (first) begin
        out_sel      <= sel_now;
        out_off_fit  <= in_off_fit;
        out_par_addr <= in_par_addr;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(policy_q) && $stable(obj_q))) else $error("configuration changed");

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !first) |=> ($stable(out_sel) && $stable(out_par_addr) && $stable(out_off_fit)))
    else $error("per-individual fields changed mid-individual");

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_beat) && $stable(out_last)
                                   && $stable(out_sel)))
    else $error("output moved during stall");

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready) else $error("input accepted during stall");
endmodule

// File: tb/tb_pareto_repl_unit.sv
module tb_pareto_repl_unit;
  localparam int BEATS = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_biased = 1'b0;
  logic [0:0]  cfg_obj = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_beat = '0;
  logic [31:0] in_off_fit = '0;
  logic [31:0] in_par_fit = '0;
  logic [5:0]  in_par_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_beat;
  logic        out_last;
  logic        out_sel;
  logic [31:0] out_off_fit;
  logic [5:0]  out_par_addr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pareto_repl_unit dut (
    .clk(clk), .rst(rst), .cfg_biased(cfg_biased), .cfg_obj(cfg_obj),
    .in_valid(in_valid), .in_ready(in_ready), .in_beat(in_beat),
    .in_off_fit(in_off_fit), .in_par_fit(in_par_fit), .in_par_addr(in_par_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_beat(out_beat),
    .out_last(out_last), .out_sel(out_sel), .out_off_fit(out_off_fit),
    .out_par_addr(out_par_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit ref_sel(input bit biased, input bit obj,
                                 input logic [31:0] off, input logic [31:0] par);
    bit ge = 1'b1, gt = 1'b0;
    if (biased) return obj ? (off[31:16] > par[31:16]) : (off[15:0] > par[15:0]);
    for (int j = 0; j < 2; j++) begin
      if (off[j*16 +: 16] < par[j*16 +: 16]) ge = 1'b0;
      if (off[j*16 +: 16] > par[j*16 +: 16]) gt = 1'b1;
    end
    return ge && gt;
  endfunction

  task automatic do_reset(input bit biased, input bit obj);
    @(negedge clk);
    cfg_biased = biased;
    cfg_obj    = obj;
    rst        = 1'b1;
    in_valid   = 1'b0;
    out_ready  = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Sends one individual with out_ready held high and checks every beat.
  task automatic send(input logic [31:0] off, input logic [31:0] par,
                      input logic [5:0] addr, input bit exp_sel, input string req);
    logic [15:0] beat;
    for (int k = 0; k < BEATS; k++) begin
      beat        = 16'($urandom);
      in_valid    = 1'b1;
      in_beat     = beat;
      in_off_fit  = (k == 0) ? off : ~off;
      in_par_fit  = (k == 0) ? par : ~par;
      in_par_addr = (k == 0) ? addr : ~addr;
      @(negedge clk);
      check(out_valid && out_beat == beat && out_last == (k == BEATS - 1), "R6",
            {out_valid, out_last, out_beat}, {1'b1, k == BEATS - 1, beat});
      check(out_sel == exp_sel, req, out_sel, exp_sel);
      check(out_off_fit == off && out_par_addr == addr, "R7",
            {out_par_addr, out_off_fit}, {addr, off});
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
  endtask

  task automatic t_pareto_directed;
    do_reset(1'b0, 1'b0);
    send({16'd5, 16'd5}, {16'd4, 16'd4}, 6'd1, 1'b1, "R2 both greater");
    send({16'd5, 16'd4}, {16'd4, 16'd4}, 6'd2, 1'b1, "R2 one greater");
    send({16'd3, 16'd9}, {16'd4, 16'd4}, 6'd3, 1'b0, "R2 trade-off");
    send({16'd1, 16'd1}, {16'd4, 16'd4}, 6'd4, 1'b0, "R2 parent dominates");
    send({16'hFFFF, 16'h0}, {16'hFFFE, 16'h0}, 6'd5, 1'b1, "R2 top of range");
    send({16'd7, 16'd7}, {16'd7, 16'd7}, 6'd6, 1'b0, "R3 equal vectors");
  endtask

  task automatic t_pareto_random;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] o, p;
      o = {16'($urandom_range(3)), 16'($urandom_range(3))};
      p = {16'($urandom_range(3)), 16'($urandom_range(3))};
      send(o, p, 6'($urandom), ref_sel(1'b0, 1'b0, o, p), (o == p) ? "R3" : "R2");
    end
  endtask

  task automatic t_biased;
    for (int ob = 0; ob < 2; ob++) begin
      do_reset(1'b1, 1'(ob));
      send(ob ? {16'd9, 16'd0} : {16'd0, 16'd9}, {16'd3, 16'd3}, 6'd7, 1'b1,
           "R4 configured objective greater");
      send({16'd3, 16'd3}, {16'd3, 16'd3}, 6'd8, 1'b0, "R4 tie");
      send(ob ? {16'd3, 16'd50} : {16'd50, 16'd3}, {16'd3, 16'd3}, 6'd9, 1'b0,
           "R4 other objective ignored");
      for (int i = 0; i < 30; i++) begin
        logic [31:0] o, p;
        o = {16'($urandom_range(3)), 16'($urandom_range(3))};
        p = {16'($urandom_range(3)), 16'($urandom_range(3))};
        send(o, p, 6'($urandom), ref_sel(1'b1, 1'(ob), o, p), "R4 random");
      end
    end
  endtask

  task automatic t_cfg_frozen;
    do_reset(1'b1, 1'b1);
    cfg_biased = 1'b0;
    cfg_obj    = 1'b0;
    send({16'd9, 16'd0}, {16'd3, 16'd5}, 6'd10, 1'b1, "R5 cfg change ignored");
    do_reset(1'b0, 1'b0);
    send({16'd9, 16'd0}, {16'd3, 16'd5}, 6'd11, 1'b0, "R5 new cfg after reset");
  endtask

  task automatic t_stall;
    logic [31:0] off = {16'd6, 16'd6};
    do_reset(1'b0, 1'b0);
    out_ready   = 1'b0;
    in_valid    = 1'b1;
    in_beat     = 16'hA001;
    in_off_fit  = off;
    in_par_fit  = {16'd2, 16'd2};
    in_par_addr = 6'd33;
    @(negedge clk);
    check(out_valid && out_beat == 16'hA001, "R8 latency", out_beat, 16'hA001);
    check(in_ready == 1'b0, "R8 ready low in stall", in_ready, 0);
    in_beat     = 16'hA002;
    in_off_fit  = 32'h0;
    in_par_fit  = 32'hFFFF_FFFF;
    in_par_addr = 6'd1;
    repeat (2) @(negedge clk);
    check(out_beat == 16'hA001 && out_valid, "R8 beat held", out_beat, 16'hA001);
    check(out_sel == 1'b1, "R8 flag held", out_sel, 1);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_beat == 16'hA002 && !out_last, "R8 resume", out_beat, 16'hA002);
    check(out_sel == 1'b1 && out_off_fit == off && out_par_addr == 6'd33, "R7 held",
          {out_par_addr, out_off_fit}, {6'd33, off});
    in_beat = 16'hA003;
    @(negedge clk);
    check(out_beat == 16'hA003 && out_last, "R6 last beat", {out_last, out_beat},
          {1'b1, 16'hA003});
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drain", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_pareto_directed();
    t_pareto_random();
    t_biased();
    t_cfg_frozen();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule